// File: doc/BRIEF.md
# Integer Add/Subtract Execute Stage with Overflow Trap

This block is the execute stage for integer addition and subtraction. It holds a general register file of 32 registers, each 32 bits wide. Every issued instruction reads its operands, computes a two's-complement sum or difference, and writes the result back. Register-form instructions read two source registers, `rs` and `rt`, and write `rd`. Immediate-form instructions add a sign-extended 16-bit constant to `rs` and write the register named by the `rt` field.

One adder serves both the trapping (signed) and the wrapping (unsigned) variants, so their result bits are always identical. Only the opcode decides whether an overflow raises a trap. A trap cancels the register write and raises a one-cycle exception flag. Register 0 always reads as zero and discards writes. Software can therefore clear a register by adding zero, and negate one by subtracting it from register 0.

The write-back port is registered and reports each instruction one clock after issue. A register written by one instruction is visible to an instruction issued in the very next cycle.

Top module: `addsub_exec_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `wb_we`, `ovf_trap`, `wb_idx` and `wb_data` are all zero.
- R2: The outputs for an instruction sampled at a rising edge with `issue_valid` high are registered at that same edge and hold for one cycle. A register it writes is read by an instruction issued in the following cycle.
- R3: Register forms use `issue_op` 0 (trapping add), 1 (wrapping add), 2 (trapping subtract) and 3 (wrapping subtract). They compute `rs + rt` or `rs - rt` modulo 2^32, write the result to `rd`, and report `rd` on `wb_idx`.
- R4: Immediate forms use `issue_op` 4 (trapping) and 5 (wrapping). They compute `rs + sign_extend(imm16)`, write the result to the register named by `rt_idx`, and report that index on `wb_idx`. A constant with bit 15 set subtracts.
- R5: Wrapping operations (1, 3, 5) never raise `ovf_trap` and always write a non-zero destination.
- R6: A trapping operation overflows when an add has operands of equal sign and a result of the other sign. A subtract overflows when `rs` and `rt` differ in sign and the result sign differs from `rs`. On overflow, `ovf_trap` is 1, `wb_we` is 0, the destination keeps its old value, and `wb_data` still shows the wrapped result.
- R7: Register 0 reads as zero. A write aimed at it changes nothing and is reported with `wb_we` = 0.
- R8: With `issue_valid` low, or with `issue_op` 6 or 7, no register is written and `wb_we`, `ovf_trap`, `wb_idx` and `wb_data` are zero in the following cycle.
- R9: `ovf_trap` is high for exactly the one cycle after each trapping instruction that overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_op | input | 3 | Operation code, values listed in R3, R4 and R8 |
| rs_idx | input | 5 | First source register |
| rt_idx | input | 5 | Second source register, or destination in immediate forms |
| rd_idx | input | 5 | Destination register in register forms |
| imm16 | input | 16 | Immediate constant, sign-extended |
| wb_we | output | 1 | The reported result was written to the register file |
| wb_idx | output | 5 | Destination register of the reported instruction |
| wb_data | output | 32 | Computed result, including when it was not written |
| ovf_trap | output | 1 | One-cycle overflow exception |

## Verification
The assertions assume that `issue_op` and the index fields are known whenever `issue_valid` is high, and that reset is held through at least one rising edge before the first instruction. The bench holds `rst` high from time zero and drives every field to a defined value at every issue. It changes inputs only at falling edges and drops `issue_valid` between instructions, so each instruction is seen exactly once. The one exception is the back-to-back pair that checks read-after-write timing. Register contents are never assumed from power-up: each register is read only after the bench has written it, or after a trap has left it at a known value.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADDU  = 3'd1,
    OP_SUB   = 3'd2,
    OP_SUBU  = 3'd3,
    OP_ADDI  = 3'd4,
    OP_ADDIU = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } addsub_op_e;

  typedef struct packed {
    logic valid;
    logic subtract;
    logic use_imm;
    logic trap_en;
  } addsub_ctrl_t;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
  import addsub_pkg::*;
(
  input  logic         issue_valid,
  input  logic [2:0]   issue_op,
  output addsub_ctrl_t ctrl
);

  addsub_op_e op;

  always_comb begin
    op   = addsub_op_e'(issue_op);
    ctrl = '0;
    unique case (op)
      OP_ADD:   ctrl = '{valid: 1'b1, subtract: 1'b0, use_imm: 1'b0, trap_en: 1'b1};
      OP_ADDU:  ctrl = '{valid: 1'b1, subtract: 1'b0, use_imm: 1'b0, trap_en: 1'b0};
      OP_SUB:   ctrl = '{valid: 1'b1, subtract: 1'b1, use_imm: 1'b0, trap_en: 1'b1};
      OP_SUBU:  ctrl = '{valid: 1'b1, subtract: 1'b1, use_imm: 1'b0, trap_en: 1'b0};
      OP_ADDI:  ctrl = '{valid: 1'b1, subtract: 1'b0, use_imm: 1'b1, trap_en: 1'b1};
      OP_ADDIU: ctrl = '{valid: 1'b1, subtract: 1'b0, use_imm: 1'b1, trap_en: 1'b0};
      default:  ctrl = '0;
    endcase
    if (!issue_valid) ctrl = '0;
  end

endmodule

// File: rtl/addsub_regfile.sv
module addsub_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);

  logic [WIDTH-1:0] mem [DEPTH];

  // single synchronous write port; entry 0 is never written
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) mem[waddr] <= wdata;
  end

  // two asynchronous read ports, entry 0 forced to zero
  assign rdata_a = (raddr_a == '0) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : mem[raddr_b];

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             overflow
);

  logic [WIDTH-1:0] b_eff;

  // subtraction as a + ~b + 1, one carry chain for both
  assign b_eff = subtract ? ~op_b : op_b;
  assign sum   = op_a + b_eff + {{(WIDTH-1){1'b0}}, subtract};

  // signed overflow: like-signed addends, result of the other sign
  assign overflow = (op_a[WIDTH-1] == b_eff[WIDTH-1]) &&
                    (sum[WIDTH-1] != op_a[WIDTH-1]);

endmodule

// File: rtl/addsub_exec_unit.sv
module addsub_exec_unit
  import addsub_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int IMMW  = 16,
  localparam int AW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  input  logic [2:0]      issue_op,
  input  logic [AW-1:0]   rs_idx,
  input  logic [AW-1:0]   rt_idx,
  input  logic [AW-1:0]   rd_idx,
  input  logic [IMMW-1:0] imm16,
  output logic            wb_we,
  output logic [AW-1:0]   wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            ovf_trap
);

  addsub_ctrl_t    ctrl;
  logic [XLEN-1:0] src_a, src_b, opnd_b, imm_ext, result;
  logic            ovf_raw, trap_now, write_now;
  logic [AW-1:0]   dst_idx;

  addsub_decode u_decode (
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .ctrl        (ctrl)
  );

  addsub_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) u_regfile (
    .clk     (clk),
    .we      (write_now),
    .waddr   (dst_idx),
    .wdata   (result),
    .raddr_a (rs_idx),
    .rdata_a (src_a),
    .raddr_b (rt_idx),
    .rdata_b (src_b)
  );

  assign imm_ext = {{(XLEN-IMMW){imm16[IMMW-1]}}, imm16};
  assign opnd_b  = ctrl.use_imm ? imm_ext : src_b;

  addsub_adder #(.WIDTH(XLEN)) u_adder (
    .op_a     (src_a),
    .op_b     (opnd_b),
    .subtract (ctrl.subtract),
    .sum      (result),
    .overflow (ovf_raw)
  );

  assign dst_idx   = ctrl.use_imm ? rt_idx : rd_idx;
  assign trap_now  = ctrl.valid && ctrl.trap_en && ovf_raw;
  assign write_now = ctrl.valid && !trap_now && (dst_idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_we    <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      ovf_trap <= 1'b0;
    end else begin
      wb_we    <= write_now;
      wb_idx   <= ctrl.valid ? dst_idx : '0;
      wb_data  <= ctrl.valid ? result : '0;
      ovf_trap <= trap_now;
    end
  end

endmodule

// File: rtl/addsub_exec_sva.sv
module addsub_exec_sva #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_valid,
  input logic [2:0]    issue_op,
  input logic [AW-1:0] rt_idx,
  input logic [AW-1:0] rd_idx,
  input logic          wb_we,
  input logic [AW-1:0] wb_idx,
  input logic          ovf_trap
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!wb_we && !ovf_trap && wb_idx == '0)); // R1

  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> !wb_we); // R6

  AST_WRAP_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (issue_op == 3'd1 || issue_op == 3'd3 || issue_op == 3'd5))
    |=> !ovf_trap); // R5

  AST_IMM_DEST: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (issue_op == 3'd4 || issue_op == 3'd5))
    |=> (wb_idx == $past(rt_idx))); // R4

  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_op < 3'd4 && rd_idx == '0) |=> !wb_we); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!issue_valid || issue_op[2:1] == 2'b11) |=> (!wb_we && !ovf_trap)); // R8

  AST_TRAP_HAS_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (ovf_trap && !$past(rst)) |-> $past(issue_valid)); // R9

endmodule

bind addsub_exec_unit addsub_exec_sva #(.AW(AW)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .issue_op    (issue_op),
  .rt_idx      (rt_idx),
  .rd_idx      (rd_idx),
  .wb_we       (wb_we),
  .wb_idx      (wb_idx),
  .ovf_trap    (ovf_trap)
);

// File: tb/addsub_exec_unit_bench.sv
module addsub_exec_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  localparam int WATCHDOG_CYCLES = 20000;

  // {op, rs, rt, rd, imm, expected data, expected write}
  localparam logic [66:0] VEC [NVEC] = '{
    {3'd5, 5'd0, 5'd1,  5'd0,  16'h7FFF, 32'h0000_7FFF, 1'b1},
    {3'd5, 5'd0, 5'd2,  5'd0,  16'hFFFF, 32'hFFFF_FFFF, 1'b1},
    {3'd1, 5'd1, 5'd1,  5'd3,  16'h0000, 32'h0000_FFFE, 1'b1},
    {3'd4, 5'd0, 5'd4,  5'd0,  16'h8000, 32'hFFFF_8000, 1'b1},
    {3'd2, 5'd0, 5'd1,  5'd5,  16'h0000, 32'hFFFF_8001, 1'b1},
    {3'd3, 5'd4, 5'd2,  5'd6,  16'h0000, 32'hFFFF_8001, 1'b1},
    {3'd0, 5'd1, 5'd0,  5'd0,  16'h0000, 32'h0000_7FFF, 1'b0},
    {3'd5, 5'd0, 5'd0,  5'd0,  16'h0005, 32'h0000_0005, 1'b0},
    {3'd1, 5'd0, 5'd0,  5'd10, 16'h0000, 32'h0000_0000, 1'b1},
    {3'd6, 5'd0, 5'd0,  5'd1,  16'h0000, 32'h0000_0000, 1'b0},
    {3'd1, 5'd1, 5'd0,  5'd0,  16'h0000, 32'h0000_7FFF, 1'b0},
    {3'd5, 5'd2, 5'd13, 5'd0,  16'h0001, 32'h0000_0000, 1'b1},
    {3'd4, 5'd1, 5'd14, 5'd0,  16'hFFFF, 32'h0000_7FFE, 1'b1},
    {3'd2, 5'd2, 5'd4,  5'd15, 16'h0000, 32'h0000_7FFF, 1'b1},
    {3'd7, 5'd3, 5'd3,  5'd3,  16'h0000, 32'h0000_0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [2:0]  issue_op = '0;
  logic [4:0]  rs_idx = '0, rt_idx = '0, rd_idx = '0;
  logic [15:0] imm16 = '0;
  logic        wb_we, ovf_trap;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_exec_unit u_addsub_exec_unit (
    .clk (clk), .rst (rst), .issue_valid (issue_valid), .issue_op (issue_op),
    .rs_idx (rs_idx), .rt_idx (rt_idx), .rd_idx (rd_idx), .imm16 (imm16),
    .wb_we (wb_we), .wb_idx (wb_idx), .wb_data (wb_data), .ovf_trap (ovf_trap)
  );

  task automatic compare(input string req, input logic [31:0] e_data,
                         input logic e_we, input logic [4:0] e_idx, input logic e_ovf);
    n_vec++;
    if (wb_data !== e_data || wb_we !== e_we || wb_idx !== e_idx || ovf_trap !== e_ovf) begin
      n_bad++;
      $display("FAIL %s: data=%h we=%b idx=%0d trap=%b, expected data=%h we=%b idx=%0d trap=%b",
               req, wb_data, wb_we, wb_idx, ovf_trap, e_data, e_we, e_idx, e_ovf);
    end
  endtask

  function automatic logic [4:0] dest_of(input logic [2:0] op, input logic [4:0] rt,
                                         input logic [4:0] rd);
    if (op >= 3'd6) return 5'd0;
    return (op >= 3'd4) ? rt : rd;
  endfunction

  // one instruction, then an idle cycle; checked half a cycle after its edge
  task automatic run(input string req, input logic [2:0] op, input logic [4:0] rs,
                     input logic [4:0] rt, input logic [4:0] rd, input logic [15:0] imm,
                     input logic [31:0] e_data, input logic e_we, input logic e_ovf);
    @(negedge clk);
    issue_valid = 1'b1; issue_op = op; rs_idx = rs; rt_idx = rt; rd_idx = rd; imm16 = imm;
    @(posedge clk);
    #1 issue_valid = 1'b0;
    @(negedge clk);
    compare(req, e_data, e_we, dest_of(op, rt, rd), e_ovf);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL R2: watchdog expired after %0d cycles, expected completion", WATCHDOG_CYCLES);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stimulus
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 during reset", 32'h0, 1'b0, 5'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    compare("R1 after reset", 32'h0, 1'b0, 5'd0, 1'b0);

    // table walk: R3 R4 R5 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      logic [66:0] v;
      string tag;
      v = VEC[i];
      if (v[66:64] >= 3'd6)                          tag = "R8 table";
      else if (dest_of(v[66:64], v[58:54], v[53:49]) == 5'd0) tag = "R7 table";
      else if (v[66:64] >= 3'd4)                     tag = "R4 table";
      else                                           tag = "R3 table";
      run($sformatf("%s row %0d", tag, i), v[66:64], v[63:59], v[58:54], v[53:49],
          v[48:33], v[32:1], v[0], 1'b0);
    end

    // build 0x80000000 in r8 by doubling (R3)
    run("R4 seed", 3'd5, 5'd0, 5'd8, 5'd0, 16'h4000, 32'h0000_4000, 1'b1, 1'b0);
    for (int k = 1; k <= 17; k++)
      run("R3 doubling", 3'd1, 5'd8, 5'd8, 5'd8, 16'h0, 32'd1 << (14 + k), 1'b1, 1'b0);
    run("R4 negative imm", 3'd5, 5'd8, 5'd9, 5'd0, 16'hFFFF, 32'h7FFF_FFFF, 1'b1, 1'b0);

    // signed overflow cases (R6) and trap pulse width (R9)
    run("R6 add pos+pos", 3'd0, 5'd9, 5'd1, 5'd10, 16'h0, 32'h8000_7FFE, 1'b0, 1'b1);
    @(negedge clk);
    compare("R9 trap gone", 32'h0, 1'b0, 5'd0, 1'b0);
    run("R6 dest kept", 3'd1, 5'd10, 5'd0, 5'd0, 16'h0, 32'h0, 1'b0, 1'b0);
    run("R5 addu wraps", 3'd1, 5'd9, 5'd1, 5'd11, 16'h0, 32'h8000_7FFE, 1'b1, 1'b0);
    run("R6 sub neg-pos", 3'd2, 5'd8, 5'd1, 5'd13, 16'h0, 32'h7FFF_8001, 1'b0, 1'b1);
    run("R6 dest kept", 3'd1, 5'd13, 5'd0, 5'd0, 16'h0, 32'h0, 1'b0, 1'b0);
    run("R5 subu wraps", 3'd3, 5'd8, 5'd1, 5'd12, 16'h0, 32'h7FFF_8001, 1'b1, 1'b0);
    run("R6 addi max+1", 3'd4, 5'd9, 5'd15, 5'd0, 16'h0001, 32'h8000_0000, 1'b0, 1'b1);
    run("R6 dest kept", 3'd1, 5'd15, 5'd0, 5'd0, 16'h0, 32'h0000_7FFF, 1'b0, 1'b0);
    run("R6 addi min-1", 3'd4, 5'd8, 5'd15, 5'd0, 16'hFFFF, 32'h7FFF_FFFF, 1'b0, 1'b1);
    run("R6 add neg+neg", 3'd0, 5'd8, 5'd8, 5'd14, 16'h0, 32'h0, 1'b0, 1'b1);
    run("R6 sub max-(-1)", 3'd2, 5'd9, 5'd2, 5'd14, 16'h0, 32'h8000_0000, 1'b0, 1'b1);
    run("R6 negate min", 3'd2, 5'd0, 5'd8, 5'd14, 16'h0, 32'h8000_0000, 1'b0, 1'b1);
    run("R6 dest kept", 3'd1, 5'd14, 5'd0, 5'd0, 16'h0, 32'h0000_7FFE, 1'b0, 1'b0);
    run("R6 trap to r0", 3'd0, 5'd9, 5'd9, 5'd0, 16'h0, 32'hFFFF_FFFE, 1'b0, 1'b1);
    run("R6 pos+neg ok", 3'd0, 5'd9, 5'd2, 5'd12, 16'h0, 32'h7FFF_FFFE, 1'b1, 1'b0);
    run("R6 min-(-1) ok", 3'd2, 5'd8, 5'd2, 5'd12, 16'h0, 32'h8000_0001, 1'b1, 1'b0);

    // R2: back-to-back read after write
    @(negedge clk);
    issue_valid = 1'b1; issue_op = 3'd5; rs_idx = 5'd0; rt_idx = 5'd7; rd_idx = 5'd0; imm16 = 16'h0003;
    @(negedge clk);
    compare("R2 first of pair", 32'h3, 1'b1, 5'd7, 1'b0);
    issue_op = 3'd1; rs_idx = 5'd7; rt_idx = 5'd7; rd_idx = 5'd0; imm16 = 16'h0;
    @(posedge clk);
    #1 issue_valid = 1'b0;
    @(negedge clk);
    compare("R2 next-cycle read", 32'h6, 1'b0, 5'd0, 1'b0);

    // R8: fields present but no issue
    @(negedge clk);
    issue_op = 3'd0; rs_idx = 5'd9; rt_idx = 5'd9; rd_idx = 5'd12;
    @(negedge clk);
    compare("R8 no issue", 32'h0, 1'b0, 5'd0, 1'b0);
    run("R8 r12 untouched", 3'd1, 5'd12, 5'd0, 5'd0, 16'h0, 32'h8000_0001, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule